// File: doc/BRIEF.md
# Prescaled Timer with Delayed Reload

The block is a small register-mapped timer. A 16-bit divider counts every clock. A control register enables counting and selects one divider bit. An 8-bit counter advances each time that selected bit, gated by the enable, goes from 1 to 0. When the counter wraps past 0xFF it reads zero for a short delay, then takes the value of an 8-bit modulo register and raises a sticky interrupt flag.

A host reaches the four registers through one address, write-enable and write-data port, and reads through a combinational read-data mux. The interrupt flag has its own write strobe, so software can clear it and can also set it. A counter write during the overflow delay cancels the pending reload. A counter write on the reload clock itself is dropped.

Top module: `prescale_timer`

## Requirements
- R1: The divider (address 0, all 16 bits on `rdata`) increases by one on every clock and wraps from 0xFFFF to 0.
- R2: Any write to address 0 sets the divider to 0 on that clock. If the gated divider bit was 1 and the cleared value makes it 0, the counter increments.
- R3: The control register (address 3) uses bit 2 as the enable and bits 1:0 as the rate select. The select codes 0, 1, 2 and 3 pick divider bits 9, 3, 5 and 7.
- R4: The counter (address 1) increments exactly when (selected divider bit AND enable) changes from 1 to 0 between clocks. Clearing the enable while the bit is 1 therefore counts once, and a disabled timer never counts.
- R5: On a wrap from 0xFF the counter reads 0 for the wrap clock and the five clocks after it. On the sixth clock after the wrap it takes the modulo value (address 2) and the interrupt flag becomes 1.
- R6: A counter write during the five delay clocks takes effect at once and cancels the reload. After the delay the counter keeps the written value and the interrupt flag is not set.
- R7: A counter write on the clock that performs the reload is dropped. The counter takes the modulo value and the interrupt flag is set.
- R8: The interrupt flag `irq_o` keeps its value until the host drives `irq_we`, which loads `irq_wval` into it (set or clear).
- R9: After reset the divider, counter, modulo, control and interrupt flag are all 0.
- R10: Outside the overflow delay, writes to the counter, modulo and control registers take effect on the next clock and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge is one timer tick |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 divider, 1 counter, 2 modulo, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data for `addr`, zero-extended |
| irq_we | input | 1 | Interrupt flag write strobe |
| irq_wval | input | 1 | Value written to the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The hardest situation to reach is a host write that lands on one exact clock of the six-clock overflow window: inside the delay for the cancel case, or on the reload clock for the dropped-write case. The stimulus makes the wrap clock predictable. It loads 0xFF into the counter, clears the divider with the fastest rate selected and the timer disabled, then enables it on the next clock. The wrap then falls exactly sixteen clocks after the clear, and the writes are placed by counting clocks from there. The enable-clear and divider-clear edges are reached the same way, by counting into the high half of bit 3's period.

// File: rtl/prescale_timer.sv
module prescale_timer #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8,
  parameter int DELAY = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [DIV_W-1:0] rdata,
  input  logic             irq_we,
  input  logic             irq_wval,
  output logic             irq_o
);
  localparam int SW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [SW-1:0] LAST = SW'(DELAY - 1);

  typedef enum logic [1:0] {S_NORM, S_OVF, S_ABORT, S_LOAD} state_t;

  logic [DIV_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, mod_q, mod_n, cnt_w, cnt_t;
  logic [2:0]       ctl_q, ctl_n;
  logic             irq_q, irq_n, gate_q, gate_n, tap, inc, carry;
  logic [CNT_W-1:0] cnt_inc;
  state_t           st_q, st_n, st_w;
  logic [SW-1:0]    step_q, step_n;

  wire wr_div = we && addr == 2'd0;
  wire wr_cnt = we && addr == 2'd1;
  wire wr_mod = we && addr == 2'd2;
  wire wr_ctl = we && addr == 2'd3;

  assign ctl_n = wr_ctl ? wdata[2:0] : ctl_q;
  assign mod_n = wr_mod ? wdata : mod_q;
  assign div_n = wr_div ? '0 : div_q + 1'b1;

  always_comb begin
    case (ctl_n[1:0])
      2'd0:    tap = div_n[9];
      2'd1:    tap = div_n[3];
      2'd2:    tap = div_n[5];
      default: tap = div_n[7];
    endcase
  end

  assign gate_n = tap & ctl_n[2];
  assign inc    = gate_q & ~gate_n;

  always_comb begin
    st_w  = st_q;
    cnt_w = cnt_q;
    if (wr_cnt && st_q != S_LOAD) cnt_w = wdata;
    if (wr_cnt && st_q == S_OVF) st_w = S_ABORT;
  end

  assign cnt_t = (st_w == S_LOAD) ? mod_n : cnt_w;
  assign irq_n = (st_w == S_LOAD) ? 1'b1 : (irq_we ? irq_wval : irq_q);
  assign {carry, cnt_inc} = {1'b0, cnt_t} + 1'b1;

  always_comb begin
    st_n   = S_NORM;
    step_n = '0;
    case (st_w)
      S_OVF: begin
        st_n   = (step_q == LAST) ? S_LOAD : S_OVF;
        step_n = (step_q == LAST) ? '0 : step_q + 1'b1;
      end
      S_ABORT: begin
        st_n   = (step_q == LAST) ? S_NORM : S_ABORT;
        step_n = (step_q == LAST) ? '0 : step_q + 1'b1;
      end
      default: ;
    endcase
    cnt_n = cnt_t;
    if (inc) begin
      cnt_n = cnt_inc;
      if (carry) begin
        st_n   = S_OVF;
        step_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      mod_q  <= '0;
      ctl_q  <= '0;
      irq_q  <= 1'b0;
      gate_q <= 1'b0;
      st_q   <= S_NORM;
      step_q <= '0;
    end else begin
      div_q  <= div_n;
      cnt_q  <= cnt_n;
      mod_q  <= mod_n;
      ctl_q  <= ctl_n;
      irq_q  <= irq_n;
      gate_q <= gate_n;
      st_q   <= st_n;
      step_q <= step_n;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = div_q;
      2'd1:    rdata = DIV_W'(cnt_q);
      2'd2:    rdata = DIV_W'(mod_q);
      default: rdata = DIV_W'(ctl_q);
    endcase
  end

  assign irq_o = irq_q;

  p_div_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> div_q == $past(div_q) + 1'b1);

  p_div_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> div_q == '0);

  p_load_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_LOAD |=> irq_o);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_we && st_q != S_LOAD) |=> $stable(irq_o));

  p_abort_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ABORT && step_q == LAST && !inc) |=> st_q == S_NORM);
endmodule

// File: tb/prescale_timer_bench.sv
`timescale 1ns/1ps
module prescale_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [15:0] rdata;
  logic        irq_we = 1'b0;
  logic        irq_wval = 1'b0;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  prescale_timer u_prescale_timer (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_we(irq_we), .irq_wval(irq_wval), .irq_o(irq_o)
  );

  localparam logic [1:0] A_DIV = 2'd0, A_CNT = 2'd1, A_MOD = 2'd2, A_CTL = 2'd3;

  // {select, clocks after divider clear, expected counter}
  localparam logic [25:0] VEC [10] = '{
    {2'd1, 16'd100,  8'd6},  {2'd1, 16'd160,  8'd10},
    {2'd2, 16'd200,  8'd3},  {2'd2, 16'd127,  8'd1},
    {2'd3, 16'd600,  8'd2},  {2'd3, 16'd511,  8'd1},
    {2'd0, 16'd1100, 8'd1},  {2'd0, 16'd2048, 8'd2},
    {2'd1, 16'd15,   8'd0},  {2'd1, 16'd16,   8'd1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic irq_set(input logic v);
    irq_we = 1'b1; irq_wval = v;
    @(negedge clk);
    irq_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic arm(input logic [1:0] sel, input logic [7:0] start);
    wr(A_CTL, {6'd0, sel});
    wr(A_CNT, start);
    wr(A_DIV, 8'd0);
    wr(A_CTL, {5'd0, 1'b1, sel});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_DIV, v); chk("R9 divider", v, 16'h0);
    rd(A_CNT, v); chk("R9 counter", v, 16'h0);
    rd(A_MOD, v); chk("R9 modulo", v, 16'h0);
    rd(A_CTL, v); chk("R9 control", v, 16'h0);
    chk("R9 irq", {15'd0, irq_o}, 16'h0);
    @(negedge clk);
    rd(A_DIV, v); chk("R1 divider advances", v, 16'h1);

    // R3 R4 R1: rate table
    for (int i = 0; i < 10; i++) begin
      arm(VEC[i][25:24], 8'd0);
      repeat (int'(VEC[i][23:8]) - 1) @(negedge clk);
      rd(A_CNT, v); chk("R3 R4 rate count", v, {8'd0, VEC[i][7:0]});
      rd(A_DIV, v); chk("R1 divider value", v, VEC[i][23:8]);
    end

    // R4: clearing enable while bit 3 is high counts once, then nothing
    arm(2'd1, 8'd0);
    repeat (8) @(negedge clk);
    wr(A_CTL, 8'h01);
    rd(A_CNT, v); chk("R4 enable clear edge", v, 16'h1);
    repeat (40) @(negedge clk);
    rd(A_CNT, v); chk("R4 disabled holds", v, 16'h1);

    // R2: divider clear while bit 3 high
    arm(2'd1, 8'd0);
    repeat (10) @(negedge clk);
    wr(A_DIV, 8'h5A);
    rd(A_CNT, v); chk("R2 divider clear edge", v, 16'h1);
    rd(A_DIV, v); chk("R2 divider zero", v, 16'h0);
    repeat (15) @(negedge clk);
    rd(A_CNT, v); chk("R2 before next edge", v, 16'h1);
    @(negedge clk);
    rd(A_CNT, v); chk("R2 next edge", v, 16'h2);

    // R10 readback
    wr(A_MOD, 8'hA0);
    rd(A_MOD, v); chk("R10 modulo", v, 16'h00A0);
    wr(A_CNT, 8'h3C);
    rd(A_CNT, v); chk("R10 counter", v, 16'h003C);

    // R8 irq set/clear
    irq_set(1'b1); chk("R8 irq set", {15'd0, irq_o}, 16'h1);
    repeat (5) @(negedge clk); chk("R8 irq held", {15'd0, irq_o}, 16'h1);
    irq_set(1'b0); chk("R8 irq clear", {15'd0, irq_o}, 16'h0);

    // R5 overflow and delayed reload
    arm(2'd1, 8'hFF);
    repeat (15) @(negedge clk);
    for (int k = 0; k <= 6; k++) begin
      rd(A_CNT, v);
      chk("R5 overflow counter", v, (k == 6) ? 16'h00A0 : 16'h0);
      chk("R5 overflow irq", {15'd0, irq_o}, (k == 6) ? 16'h1 : 16'h0);
      if (k < 6) @(negedge clk);
    end
    irq_set(1'b0);

    // R6 cancelled reload, including a second write in the cancelled delay
    arm(2'd1, 8'hFF);
    repeat (15) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(A_CNT, 8'h33);
    rd(A_CNT, v); chk("R6 write taken", v, 16'h0033);
    wr(A_CNT, 8'h44);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R6 no reload", v, 16'h0044);
    chk("R6 no irq", {15'd0, irq_o}, 16'h0);

    // R7 write on reload clock dropped
    arm(2'd1, 8'hFF);
    repeat (15) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(A_CNT, 8'h55);
    rd(A_CNT, v); chk("R7 write dropped", v, 16'h00A0);
    chk("R7 irq set", {15'd0, irq_o}, 16'h1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule